// File: doc/BRIEF.md
# Dual-Channel Phase Comparator with Lock Qualifier and Monitor Pin

This block sits between the divider chains and the charge pumps of a two-channel frequency synthesizer. For each channel it watches the divided reference train and the divided feedback train, and issues digital pump-up, pump-down and pump-enable commands. The analog pump current is not modelled. A per-channel current-level bit is passed to the pump as a one-bit level. A per-channel sense bit swaps the up and down commands, so the loop can drive an oscillator whose tuning slope is either positive or negative.

Each comparator has two flags. The first rising edge of either train sets its flag. Once both flags would be set, the comparison is complete and both flags clear together. A lock qualifier measures how many cycles each phase-error pulse lasts. It declares a channel locked after a run of short pulses, and drops the lock after any one long pulse. A shared monitor output is registered. It carries one of four things: a lock indication, one raw divider train for test, a constant low while the downstream counters are commanded to reset, or nothing.

Top module: `dual_pfd_lock_monitor`

## Requirements
- R1: A rising edge on ref_div[i] that comes before the matching rising edge on fb_div[i] raises the pending command one cycle after the ref edge. The command stays high until the cycle after the fb edge. With phase_inv[i]=0 the command is pump_up[i]; when fb leads, it is pump_dn[i]. Edges that fall in the same cycle produce neither command.
- R2: phase_inv[i]=1 swaps pump_up[i] and pump_dn[i].
- R3: force_hiz=1 drives pump_en, pump_up and pump_dn low on both channels.
- R4: pwr_down[i]=1 does the following on channel i only: pump_en[i] goes low, the comparator flags clear, the comparator ignores edges, and the lock is lost. The other channel is not affected.
- R5: cp_level[i] follows cp_hi[i] in the same cycle.
- R6: A channel becomes locked after CONFIRM consecutive comparisons (default 4) whose error pulse is shorter than ERR_LIM cycles (default 4). A single comparison of ERR_LIM cycles or more unlocks it.
- R7: While a channel is locked, its lock indication goes low during each pending comparison and returns high afterwards. An unlocked channel's indication stays low.
- R8: With mon_mode=00, the mon_chan value selects what mon_pin carries:
  - 00: low
  - 01: lock indication of channel 0
  - 10: lock indication of channel 1
  - 11: AND of both lock indications
- R9: With mon_mode=01, mon_pin carries ref_div of the channel that mon_chan[1] selects (0 selects channel 0).
- R10: With mon_mode=10, mon_pin carries fb_div of the channel that mon_chan[1] selects.
- R11: With mon_mode=11, mon_pin is low and div_reset equals mon_chan. In every other mode, div_reset is 00.
- R12: mon_pin is registered one cycle after its selected source. After reset, mon_pin, pump_up and pump_dn are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_div | input | 2 | Divided reference train per channel |
| fb_div | input | 2 | Divided feedback train per channel |
| phase_inv | input | 2 | Sense swap per channel |
| cp_hi | input | 2 | Pump current level select per channel |
| force_hiz | input | 1 | Forces both pumps to high impedance |
| pwr_down | input | 2 | Channel power-down |
| mon_mode | input | 2 | Monitor source class |
| mon_chan | input | 2 | Monitor channel selection |
| pump_up | output | 2 | Pump-up command per channel |
| pump_dn | output | 2 | Pump-down command per channel |
| pump_en | output | 2 | Pump drive enable (low = high impedance) |
| cp_level | output | 2 | Pump current level per channel |
| div_reset | output | 2 | Counter reset command per channel |
| mon_pin | output | 1 | Shared monitor output |

## Verification
A pump command appears one cycle after the edge that raises it, and it drops one cycle after the edge that completes the comparison. The lock state changes at the edge that completes the deciding comparison. mon_pin adds one more register after that. The enable, current-level and div_reset outputs respond in the same cycle as their inputs. The bench drives inputs and samples outputs on falling clock edges, so it counts exactly which falling edge each result belongs to. It checks pump commands on the first falling edge after the rising edge that acts. It reads the lock and monitor results only after several idle cycles, except in the mid-comparison check of R7, which targets the second falling edge.

// File: rtl/pdm_pkg.sv
// Shared types for the dual phase comparator and monitor block.
// Assumes exactly two channels; the monitor encodings depend on that.
package pdm_pkg;
    localparam int NCH = 2;

    typedef enum logic [1:0] {
        MON_LOCK = 2'b00,
        MON_REF  = 2'b01,
        MON_FB   = 2'b10,
        MON_RST  = 2'b11
    } mon_mode_e;
endpackage

// File: rtl/pdm_pfd.sv
// Two-flag phase-frequency comparator for one channel.
// Detects rising edges of the synchronous divider trains. A ref edge sets
// the lead flag and a fb edge sets the lag flag. When both would be set,
// both clear and done_o pulses. Assumes inputs are synchronous to clk.
module pdm_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ref_i,
    input  logic fb_i,
    output logic up_o,
    output logic dn_o,
    output logic pend_o,
    output logic done_o
);
    logic ref_q, fb_q, up_q, dn_q;
    logic ref_edge, fb_edge, up_n, dn_n;

    assign ref_edge = ref_i & ~ref_q;
    assign fb_edge  = fb_i & ~fb_q;
    assign up_n     = up_q | ref_edge;
    assign dn_n     = dn_q | fb_edge;
    assign done_o   = enable & up_n & dn_n;

    // Purpose: remember previous input levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            fb_q  <= 1'b0;
        end else begin
            ref_q <= ref_i;
            fb_q  <= fb_i;
        end
    end

    // Purpose: set flags on edges, clear both once the comparison completes.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (up_n && dn_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_n;
            dn_q <= dn_n;
        end
    end

    assign up_o   = up_q;
    assign dn_o   = dn_q;
    assign pend_o = up_q | dn_q;

    AST_NO_DOUBLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_q && dn_q)); // R1
    AST_PD_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!up_q && !dn_q)); // R4
endmodule

// File: rtl/pdm_lock.sv
// Lock qualifier for one channel.
// Counts the cycles of each phase-error pulse. A completed comparison
// shorter than ERR_LIM cycles advances a saturating run counter; a longer
// one resets it. Locked once the run reaches CONFIRM. Power-down clears all.
module pdm_lock #(
    parameter int ERR_LIM = 4,
    parameter int CONFIRM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pend,
    input  logic done,
    output logic locked_o
);
    localparam int EW = $clog2(ERR_LIM + 2);
    localparam int GW = $clog2(CONFIRM + 1);

    logic [EW-1:0] err_cnt, width;
    logic [GW-1:0] good_cnt;
    logic          good, locked_q;

    assign width = err_cnt + EW'(pend);
    assign good  = width < EW'(ERR_LIM);

    // Purpose: measure the length of the current error pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || done)
            err_cnt <= '0;
        else if (pend && err_cnt < EW'(ERR_LIM))
            err_cnt <= err_cnt + 1'b1;
    end

    // Purpose: count consecutive short comparisons and hold the lock state.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            good_cnt <= '0;
            locked_q <= 1'b0;
        end else if (done) begin
            if (!good) begin
                good_cnt <= '0;
                locked_q <= 1'b0;
            end else if (good_cnt < GW'(CONFIRM)) begin
                good_cnt <= good_cnt + 1'b1;
                locked_q <= (good_cnt + 1'b1) == GW'(CONFIRM);
            end
        end
    end

    assign locked_o = locked_q;

    AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= EW'(ERR_LIM)); // R6
    AST_WIDE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !good) |=> !locked_q); // R6
    AST_PD_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !locked_q); // R4
endmodule

// File: rtl/pdm_mon.sv
// Registered monitor output selector and counter reset decode.
// Assumes two channels: in divider modes mon_chan[1] picks the channel.
module pdm_mon
    import pdm_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  mon_mode_e      mode,
    input  logic [NCH-1:0] chan,
    input  logic [NCH-1:0] lock_ind,
    input  logic [NCH-1:0] ref_i,
    input  logic [NCH-1:0] fb_i,
    output logic [NCH-1:0] div_reset,
    output logic           mon_o
);
    logic mon_n;

    // Purpose: choose the monitor source for the next cycle.
    always_comb begin
        case (mode)
            MON_LOCK: begin
                case (chan)
                    2'b01:   mon_n = lock_ind[0];
                    2'b10:   mon_n = lock_ind[1];
                    2'b11:   mon_n = &lock_ind;
                    default: mon_n = 1'b0;
                endcase
            end
            MON_REF: mon_n = ref_i[chan[1]];
            MON_FB:  mon_n = fb_i[chan[1]];
            default: mon_n = 1'b0;
        endcase
    end

    assign div_reset = (mode == MON_RST) ? chan : '0;

    // Purpose: register the monitor pin.
    always_ff @(posedge clk) begin
        if (!rst_n) mon_o <= 1'b0;
        else        mon_o <= mon_n;
    end

    AST_RST_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MON_RST) |=> !mon_o); // R11
endmodule

// File: rtl/dual_pfd_lock_monitor.sv
// Top: two phase comparators with lock qualifiers, sense swap, forced
// high impedance, power-down and a shared registered monitor pin.
// Assumes all inputs are synchronous to clk.
module dual_pfd_lock_monitor
    import pdm_pkg::*;
#(
    parameter int ERR_LIM = 4,
    parameter int CONFIRM = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ref_div,
    input  logic [1:0] fb_div,
    input  logic [1:0] phase_inv,
    input  logic [1:0] cp_hi,
    input  logic       force_hiz,
    input  logic [1:0] pwr_down,
    input  logic [1:0] mon_mode,
    input  logic [1:0] mon_chan,
    output logic [1:0] pump_up,
    output logic [1:0] pump_dn,
    output logic [1:0] pump_en,
    output logic [1:0] cp_level,
    output logic [1:0] div_reset,
    output logic       mon_pin
);
    logic [NCH-1:0] up_f, dn_f, pend, done, locked, lock_ind;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pdm_pfd u_pfd (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (~pwr_down[i]),
            .ref_i  (ref_div[i]),
            .fb_i   (fb_div[i]),
            .up_o   (up_f[i]),
            .dn_o   (dn_f[i]),
            .pend_o (pend[i]),
            .done_o (done[i])
        );

        pdm_lock #(.ERR_LIM(ERR_LIM), .CONFIRM(CONFIRM)) u_lock (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (~pwr_down[i]),
            .pend     (pend[i]),
            .done     (done[i]),
            .locked_o (locked[i])
        );

        assign pump_en[i]  = ~force_hiz & ~pwr_down[i];
        assign pump_up[i]  = pump_en[i] & (phase_inv[i] ? dn_f[i] : up_f[i]);
        assign pump_dn[i]  = pump_en[i] & (phase_inv[i] ? up_f[i] : dn_f[i]);
        assign cp_level[i] = cp_hi[i];
        assign lock_ind[i] = locked[i] & ~pend[i];
    end

    pdm_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mon_mode_e'(mon_mode)),
        .chan      (mon_chan),
        .lock_ind  (lock_ind),
        .ref_i     (ref_div),
        .fb_i      (fb_div),
        .div_reset (div_reset),
        .mon_o     (mon_pin)
    );

    AST_HIZ_NO_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
        force_hiz |-> (pump_up == 2'b00 && pump_dn == 2'b00)); // R3
endmodule

// File: tb/test_dual_pfd_lock_monitor.sv
module test_dual_pfd_lock_monitor;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_div = '0, fb_div = '0, phase_inv = '0, cp_hi = '0;
    logic       force_hiz = 1'b0;
    logic [1:0] pwr_down = '0, mon_mode = '0, mon_chan = '0;
    logic [1:0] pump_up, pump_dn, pump_en, cp_level, div_reset;
    logic       mon_pin;
    int         checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    dual_pfd_lock_monitor i_dual_pfd_lock_monitor (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
        .phase_inv(phase_inv), .cp_hi(cp_hi), .force_hiz(force_hiz),
        .pwr_down(pwr_down), .mon_mode(mon_mode), .mon_chan(mon_chan),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en),
        .cp_level(cp_level), .div_reset(div_reset), .mon_pin(mon_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One comparison on channel ch; the leading edge comes d cycles before the lagging one.
    task automatic pair(input int ch, input bit ref_first, input int d,
                        input bit eu, input bit ed, input string req);
        @(negedge clk);
        if (d == 0) begin
            ref_div[ch] = 1'b1; fb_div[ch] = 1'b1;
        end else if (ref_first) ref_div[ch] = 1'b1;
        else fb_div[ch] = 1'b1;
        @(negedge clk);
        chk({req, " up during"}, int'(pump_up[ch]), (d > 0) ? int'(eu) : 0);
        chk({req, " dn during"}, int'(pump_dn[ch]), (d > 0) ? int'(ed) : 0);
        if (d > 0) begin
            repeat (d - 1) @(negedge clk);
            if (ref_first) fb_div[ch] = 1'b1;
            else ref_div[ch] = 1'b1;
            @(negedge clk);
            chk({req, " up after"}, int'(pump_up[ch]), 0);
            chk({req, " dn after"}, int'(pump_dn[ch]), 0);
        end
        ref_div[ch] = 1'b0; fb_div[ch] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R12 mon_pin reset", int'(mon_pin), 0);
        chk("R12 pump_up reset", int'(pump_up), 0);
        chk("R12 pump_dn reset", int'(pump_dn), 0);
    endtask

    task automatic test_pfd();
        pair(0, 1'b1, 3, 1'b1, 1'b0, "R1 ref leads");
        pair(0, 1'b0, 2, 1'b0, 1'b1, "R1 fb leads");
        pair(1, 1'b1, 1, 1'b1, 1'b0, "R1 ch1 ref leads");
        pair(0, 1'b1, 0, 1'b0, 1'b0, "R1 coincident");
    endtask

    task automatic test_polarity();
        phase_inv = 2'b01;
        pair(0, 1'b1, 2, 1'b0, 1'b1, "R2 inverted ref leads");
        pair(0, 1'b0, 2, 1'b1, 1'b0, "R2 inverted fb leads");
        phase_inv = 2'b00;
    endtask

    task automatic test_hiz_and_level();
        @(negedge clk);
        force_hiz = 1'b1;
        #1 chk("R3 pump_en both off", int'(pump_en), 0);
        pair(0, 1'b1, 2, 1'b0, 1'b0, "R3 hiz no command");
        force_hiz = 1'b0;
        cp_hi = 2'b10;
        #1 chk("R5 cp_level", int'(cp_level), 2);
        cp_hi = 2'b01;
        #1 chk("R5 cp_level", int'(cp_level), 1);
    endtask

    task automatic lock_ch(input int ch, input string req);
        for (int k = 0; k < 4; k++) pair(ch, 1'b1, 1, 1'b1, 1'b0, req);
    endtask

    task automatic test_lock();
        mon_mode = 2'b00; mon_chan = 2'b01;
        pair(0, 1'b1, 5, 1'b1, 1'b0, "R6 wide clears");
        chk("R6 unlocked start", int'(mon_pin), 0);
        for (int k = 0; k < 3; k++) pair(0, 1'b1, 1, 1'b1, 1'b0, "R6 short");
        chk("R6 not yet after 3", int'(mon_pin), 0);
        pair(0, 1'b1, 1, 1'b1, 1'b0, "R6 short");
        chk("R6 locked after 4", int'(mon_pin), 1);
        // R7: indication low while a comparison is pending
        @(negedge clk); ref_div[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 low during pending", int'(mon_pin), 0);
        fb_div[0] = 1'b1;
        @(negedge clk);
        ref_div[0] = 1'b0; fb_div[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 high after pending", int'(mon_pin), 1);
        pair(0, 1'b1, 5, 1'b1, 1'b0, "R6 wide pulse");
        chk("R6 unlocked by wide", int'(mon_pin), 0);
    endtask

    task automatic test_mon_lock();
        lock_ch(0, "R8 lock ch0");
        mon_chan = 2'b10;
        lock_ch(1, "R8 lock ch1");
        chk("R8 ch1 select", int'(mon_pin), 1);
        mon_chan = 2'b11;
        repeat (2) @(negedge clk);
        chk("R8 both locked AND", int'(mon_pin), 1);
        mon_chan = 2'b00;
        repeat (2) @(negedge clk);
        chk("R8 disabled", int'(mon_pin), 0);
        mon_chan = 2'b11;
        pair(1, 1'b1, 5, 1'b1, 1'b0, "R8 unlock ch1");
        chk("R8 AND one unlocked", int'(mon_pin), 0);
        mon_chan = 2'b01;
        repeat (2) @(negedge clk);
        chk("R8 ch0 still locked", int'(mon_pin), 1);
    endtask

    task automatic test_powerdown();
        @(negedge clk);
        pwr_down = 2'b01;
        #1 chk("R4 pump_en ch0 off", int'(pump_en[0]), 0);
        chk("R4 pump_en ch1 on", int'(pump_en[1]), 1);
        repeat (2) @(negedge clk);
        chk("R4 lock lost", int'(mon_pin), 0);
        pair(0, 1'b1, 2, 1'b0, 1'b0, "R4 comparator idle");
        pair(1, 1'b1, 2, 1'b1, 1'b0, "R4 ch1 unaffected");
        pwr_down = 2'b00;
        repeat (2) @(negedge clk);
        chk("R4 lock stays lost", int'(mon_pin), 0);
    endtask

    task automatic test_mon_div();
        mon_mode = 2'b01; mon_chan = 2'b00;
        @(negedge clk); ref_div[0] = 1'b1;
        @(negedge clk); chk("R9 ref ch0 high", int'(mon_pin), 1);
        ref_div[0] = 1'b0;
        @(negedge clk); chk("R9 ref ch0 low", int'(mon_pin), 0);
        chk("R11 div_reset idle", int'(div_reset), 0);
        mon_chan = 2'b10;
        @(negedge clk); ref_div[1] = 1'b1; ref_div[0] = 1'b1;
        @(negedge clk); chk("R9 ref ch1 high", int'(mon_pin), 1);
        ref_div[1] = 1'b0;
        @(negedge clk); chk("R9 ref ch1 low", int'(mon_pin), 0);
        mon_mode = 2'b10; mon_chan = 2'b00;
        @(negedge clk); fb_div[0] = 1'b1;
        @(negedge clk); chk("R10 fb ch0 high", int'(mon_pin), 1);
        fb_div[0] = 1'b0; ref_div[0] = 1'b0;
        @(negedge clk); chk("R10 fb ch0 low", int'(mon_pin), 0);
        mon_chan = 2'b10;
        @(negedge clk); fb_div[1] = 1'b1;
        @(negedge clk); chk("R10 fb ch1 high", int'(mon_pin), 1);
        mon_mode = 2'b11; mon_chan = 2'b11;
        #1 chk("R11 div_reset", int'(div_reset), 3);
        @(negedge clk); chk("R11 pin low", int'(mon_pin), 0);
        fb_div[1] = 1'b0;
        mon_chan = 2'b01;
        #1 chk("R11 div_reset ch0", int'(div_reset), 1);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_pfd();
        test_polarity();
        test_hiz_and_level();
        test_lock();
        test_mon_lock();
        test_powerdown();
        test_mon_div();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule